// File: doc/BRIEF.md
# Interrupt Queue Pointer Monitor

This block keeps the head and tail pointer registers of four interrupt queues that live in memory: a processor-to-processor message queue, a device message queue, a resumable error queue and a non-resumable error queue. Software reaches every pointer through a simple register port, writing it and reading it back. The queue memory, the wrap arithmetic on the pointers and the trap handling are outside this block.

A queue counts as non-empty when its head pointer and its tail pointer differ. For three of the four queues the block raises a level interrupt whenever that queue is non-empty. The non-resumable error queue keeps its pair of pointers like the others but never raises an interrupt. Each interrupt follows the stored pointers, so it moves in the cycle after the write that changed them.

Top module: `irq_queue_monitor`

## Requirements
- R1: After reset every pointer reads as zero and all three interrupt outputs are low.
- R2: A write to any of the eight pointers stores the full write data. Selectors are regAddr[2:1] for the queue (0 = processor message, 1 = device message, 2 = resumable error, 3 = non-resumable error) and regAddr[0] for the pointer (0 = head, 1 = tail). A later read at the same address returns that value and leaves the other seven pointers unchanged.
- R3: readData is combinational. It shows the pointer selected by regAddr in the same cycle, and it reflects a write starting in the cycle after that write's clock edge.
- R4: irqCpuMsg is high exactly when the processor message head differs from its tail, one cycle after the write that creates or removes the difference.
- R5: irqDevMsg is high exactly when the device message head differs from its tail.
- R6: irqResErr is high exactly when the resumable error head differs from its tail.
- R7: The non-resumable error pointers are stored and read back, but no value written to them changes any interrupt output.
- R8: A write to either the head or the tail of a queue updates that queue's interrupt. Writing a value equal to the other pointer clears the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Write strobe for the register port |
| regAddr | input | 3 | Pointer select: bits 2:1 queue, bit 0 head(0)/tail(1) |
| regWrData | input | PTR_W | Write data |
| regRdData | output | PTR_W | Read data for the selected pointer |
| irqCpuMsg | output | 1 | Processor message queue non-empty |
| irqDevMsg | output | 1 | Device message queue non-empty |
| irqResErr | output | 1 | Resumable error queue non-empty |

## Verification
The bench builds the block with its default 64-bit pointers. That lets it write patterns that differ from the other pointer only in the top bit or only in the bottom bit, which exercises the full width of each head/tail comparator. Random writes use small values drawn from a narrow range, so pointers become equal often and each interrupt both rises and falls many times. Directed writes to the non-resumable pair, including values that differ from its partner, show that this queue never raises an interrupt.

// File: rtl/iqm_pkg.sv
package iqm_pkg;
  localparam int NUM_Q = 4;
  localparam int QSEL_W = $clog2(NUM_Q);
  localparam int ADDR_W = QSEL_W + 1;
  localparam int NUM_IRQ = 3;

  typedef enum logic [QSEL_W-1:0] {
    Q_CPU_MSG = 2'd0,
    Q_DEV_MSG = 2'd1,
    Q_RES_ERR = 2'd2,
    Q_NRES_ERR = 2'd3
  } queue_e;

  typedef struct packed {
    logic [NUM_Q-1:0] headWe;
    logic [NUM_Q-1:0] tailWe;
  } ptr_strobe_t;
endpackage

// File: rtl/iqm_ctrl.sv
module iqm_ctrl
  import iqm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output ptr_strobe_t       strobes
);
  logic [QSEL_W-1:0] qSel;
  logic isTail;

  assign qSel   = regAddr[ADDR_W-1:1];
  assign isTail = regAddr[0];

  always_comb begin
    strobes = '0;
    for (int q = 0; q < NUM_Q; q++) begin
      if (regWrEn && qSel == QSEL_W'(q)) begin
        strobes.headWe[q] = !isTail;
        strobes.tailWe[q] = isTail;
      end
    end
  end

  // R2: exactly one pointer register is written per write cycle
  p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> $countones({strobes.headWe, strobes.tailWe}) == 1);
  p_no_strobe_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |-> ({strobes.headWe, strobes.tailWe} == '0));
endmodule

// File: rtl/iqm_datapath.sv
module iqm_datapath
  import iqm_pkg::*;
#(
  parameter int PTR_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ptr_strobe_t       strobes,
  input  logic [PTR_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [PTR_W-1:0]  rdData,
  output logic [NUM_Q-1:0]  nonEmpty
);
  logic [PTR_W-1:0] headQ [NUM_Q];
  logic [PTR_W-1:0] tailQ [NUM_Q];

  for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
    always_ff @(posedge clk) begin
      if (!rstN) begin
        headQ[q] <= '0;
        tailQ[q] <= '0;
      end else begin
        if (strobes.headWe[q]) headQ[q] <= wrData;
        if (strobes.tailWe[q]) tailQ[q] <= wrData;
      end
    end
    assign nonEmpty[q] = headQ[q] != tailQ[q];

    // R2: unselected pointers keep their value
    p_hold_head_r2: assert property (@(posedge clk) disable iff (!rstN)
      !strobes.headWe[q] |=> $stable(headQ[q]));
    p_hold_tail_r2: assert property (@(posedge clk) disable iff (!rstN)
      !strobes.tailWe[q] |=> $stable(tailQ[q]));
  end

  always_comb begin
    if (rdAddr[0]) rdData = tailQ[rdAddr[ADDR_W-1:1]];
    else           rdData = headQ[rdAddr[ADDR_W-1:1]];
  end
endmodule

// File: rtl/irq_queue_monitor.sv
module irq_queue_monitor
  import iqm_pkg::*;
#(
  parameter int PTR_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [PTR_W-1:0]  regWrData,
  output logic [PTR_W-1:0]  regRdData,
  output logic              irqCpuMsg,
  output logic              irqDevMsg,
  output logic              irqResErr
);
  ptr_strobe_t strobes;
  logic [NUM_Q-1:0] nonEmpty;

  iqm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .strobes(strobes)
  );

  iqm_datapath #(.PTR_W(PTR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(regWrData),
    .rdAddr(regAddr), .rdData(regRdData), .nonEmpty(nonEmpty)
  );

  assign irqCpuMsg = nonEmpty[Q_CPU_MSG];
  assign irqDevMsg = nonEmpty[Q_DEV_MSG];
  assign irqResErr = nonEmpty[Q_RES_ERR];

  // R1: interrupts low in the first cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> !irqCpuMsg && !irqDevMsg && !irqResErr);
  // R7/R8: a write to the silent queue never toggles an interrupt
  p_silent_queue_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr[ADDR_W-1:1] == Q_NRES_ERR) |=>
      $stable({irqCpuMsg, irqDevMsg, irqResErr}));
  // R4: with no write, the processor message interrupt holds
  p_cpu_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> $stable(irqCpuMsg));
endmodule

// File: tb/irq_queue_monitor_test.sv
module irq_queue_monitor_test;
  localparam int CLK_PERIOD = 10;
  localparam int PTR_W = 64;

  logic clk = 0;
  logic rstN = 0;
  logic regWrEn = 0;
  logic [2:0] regAddr = '0;
  logic [PTR_W-1:0] regWrData = '0;
  logic [PTR_W-1:0] regRdData;
  logic irqCpuMsg, irqDevMsg, irqResErr;

  int errors = 0;
  int checks = 0;
  logic [PTR_W-1:0] model [8];

  irq_queue_monitor #(.PTR_W(PTR_W)) uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .irqCpuMsg(irqCpuMsg), .irqDevMsg(irqDevMsg), .irqResErr(irqResErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic logic [2:0] expIrq();
    return {model[4] != model[5], model[2] != model[3], model[0] != model[1]};
  endfunction

  task automatic check(input string req, input logic [PTR_W-1:0] act, input logic [PTR_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [PTR_W-1:0] d);
    @(negedge clk);
    regWrEn = 1; regAddr = 3'(a); regWrData = d;
    @(negedge clk);
    regWrEn = 0;
    model[a] = d;
  endtask

  task automatic checkIrq(input string req);
    check(req, {61'd0, irqResErr, irqDevMsg, irqCpuMsg}, {61'd0, expIrq()});
  endtask

  task automatic checkAll(input string req);
    for (int a = 0; a < 8; a++) begin
      regAddr = 3'(a); #1;
      check(req, regRdData, model[a]);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int a = 0; a < 8; a++) model[a] = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    checkIrq("R1");
    checkAll("R1");
    // R2/R3 write and read back each pointer
    for (int a = 0; a < 8; a++) begin
      wr(a, {32'hA5A5_0000, 32'(a)});
      regAddr = 3'(a); #1; check("R3", regRdData, model[a]);
    end
    checkAll("R2");
    checkIrq("R8");
    // R4 top-bit difference on processor message queue
    wr(0, 64'h8000_0000_0000_0000); wr(1, 64'h0);
    checkIrq("R4");
    wr(1, 64'h8000_0000_0000_0000); checkIrq("R8");
    // R5 low-bit difference
    wr(2, 64'h1); wr(3, 64'h0); checkIrq("R5");
    wr(2, 64'h0); checkIrq("R8");
    // R6
    wr(5, 64'hFFFF_FFFF_FFFF_FFFF); wr(4, 64'h0); checkIrq("R6");
    wr(4, 64'hFFFF_FFFF_FFFF_FFFF); checkIrq("R6");
    // R7 silent queue
    wr(6, 64'h0); wr(7, 64'h1234);
    checkIrq("R7");
    check("R7", {61'd0, irqResErr, irqDevMsg, irqCpuMsg}, 64'd0);
    regAddr = 3'd7; #1; check("R7", regRdData, 64'h1234);
    // random phase
    for (int i = 0; i < 400; i++) begin
      wr(int'($urandom_range(0, 7)), 64'($urandom_range(0, 3)));
      checkIrq("R8");
    end
    checkAll("R2");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule